// File: doc/BRIEF.md
# Wide-Word Warp Request Splitter

This block sits between a warp's load/store issue point and the memory hierarchy. It accepts one warp-wide memory request at a time. A request carries one address per lane, an active-lane mask, a word-size code and a caching-mode bit. The block breaks the request into lane groups. Narrow words keep the whole warp as one group. Double words split it into two halves, and quad words split it into four quarters. The groups are processed strictly one after another.

For each group, the block finds every distinct aligned memory block that the group's active lanes touch. It emits one record per block, in ascending address order. Each record carries the aligned address, a size flag and the mask of lanes it serves. The block size is a full 128-byte line in the two-level caching mode and a 32-byte sector in the second-level-only mode.

The request side and the record side each use a valid/ready handshake. A one-cycle done pulse closes each request. Caches, DRAM and the return of data are handled elsewhere.

Top module: `wsp_splitter`

## Requirements
- R1: `req_ready` is high exactly when no request is in progress. While a request is being split, a new request is not taken and does not change the records being produced.
- R2: With word-size code 0 (4 bytes or less), all lanes form one group. A single record may serve lanes from both halves of the warp.
- R3: With word-size code 1 (8 bytes), lanes 0–15 form the first group and lanes 16–31 the second. All records of the first group are emitted before any record of the second.
- R4: With word-size code 2 or 3 (16 bytes), there are four groups of 8 consecutive lanes, processed in lane order 0–7, 8–15, 16–23, 24–31.
- R5: With `req_l2only`=0, every record address is 128-byte aligned and `out_sector`=0. With `req_l2only`=1, every record address is 32-byte aligned and `out_sector`=1.
- R6: Inactive lanes contribute no address and never appear in `out_lanes`. A group with no active lane emits nothing, and an all-zero mask produces no record at all.
- R7: Within a group, records come in strictly ascending address order. Each touched block appears once, and its lane mask holds every active lane of that group whose address falls in that block.
- R8: While `out_valid` is high and `out_ready` is low, the record (`out_addr`, `out_sector`, `out_lanes`) stays unchanged.
- R9: `done` pulses for one cycle after the last record of a request has been taken, or after the group walk of a request with no record. It is never high together with `out_valid`.
- R10: Address bits below the block size are ignored. Lanes whose addresses differ only in those bits share one record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Warp request offered |
| req_ready | output | 1 | Splitter idle, request taken on valid |
| req_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| req_mask | input | LANES | Active lanes |
| req_wsize | input | 2 | Word size code: 0 = up to 4 B, 1 = 8 B, 2/3 = 16 B |
| req_l2only | input | 1 | 1 = 32-byte transactions, 0 = 128-byte transactions |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Record consumer ready |
| out_addr | output | ADDR_W | Aligned block address |
| out_sector | output | 1 | 1 = 32-byte transaction, 0 = 128-byte line |
| out_lanes | output | LANES | Lanes served by this record |
| done | output | 1 | One-cycle pulse ending a request |

## Verification
The bench builds the block with its defaults: 32 lanes, 32-bit addresses, 128-byte lines and 32-byte sectors. These values make the full four-quarter split reachable, as well as line straddles within a narrow-word warp and warps whose lanes land in 32 separate blocks. Stimulus patterns include forward and reversed lane strides, all lanes aliasing one address, and sparse masks that leave whole groups empty. Consumer stalls of varying rhythm exercise record holding, and a competing request offered mid-split shows that it has no effect.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
   localparam logic [1:0] WSZ_WORD = 2'd0;
   localparam logic [1:0] WSZ_DBL  = 2'd1;
   localparam logic [1:0] WSZ_QUAD = 2'd2;

   function automatic logic [1:0] wsp_last_group(input logic [1:0] wsz);
      case (wsz)
         WSZ_WORD: return 2'd0;
         WSZ_DBL:  return 2'd1;
         default:  return 2'd3;
      endcase
   endfunction
endpackage

// File: rtl/wsp_group_sel.sv
module wsp_group_sel
   import wsp_pkg::*;
#(
   parameter int LANES = 32
) (
   input  logic [1:0]       wsz,
   input  logic [1:0]       grp,
   output logic [LANES-1:0] sel
);
   localparam int HALF  = LANES / 2;
   localparam int QUART = LANES / 4;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam logic [1:0] HID = 2'(l / HALF);
      localparam logic [1:0] QID = 2'(l / QUART);
      assign sel[l] = (wsz == WSZ_WORD) ? (grp == 2'd0) :
                      (wsz == WSZ_DBL)  ? (grp == HID)  :
                                          (grp == QID);
   end
endmodule

// File: rtl/wsp_blk_align.sv
module wsp_blk_align #(
   parameter int LANES        = 32,
   parameter int ADDR_W       = 32,
   parameter int LINE_BYTES   = 128,
   parameter int SECTOR_BYTES = 32
) (
   input  logic [LANES*ADDR_W-1:0] addr_flat,
   input  logic                    sector_mode,
   output logic [LANES*ADDR_W-1:0] blk_flat
);
   localparam logic [ADDR_W-1:0] LINE_OFS = ADDR_W'(LINE_BYTES - 1);
   localparam logic [ADDR_W-1:0] SECT_OFS = ADDR_W'(SECTOR_BYTES - 1);

   logic [ADDR_W-1:0] ofs_mask;
   assign ofs_mask = sector_mode ? SECT_OFS : LINE_OFS;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign blk_flat[l*ADDR_W +: ADDR_W] = addr_flat[l*ADDR_W +: ADDR_W] & ~ofs_mask;
   end
endmodule

// File: rtl/wsp_min_pick.sv
module wsp_min_pick #(
   parameter int LANES  = 32,
   parameter int ADDR_W = 32
) (
   input  logic [LANES*ADDR_W-1:0] blk_flat,
   input  logic [LANES-1:0]        pend,
   output logic [ADDR_W-1:0]       min_addr,
   output logic [LANES-1:0]        hit
);
   always_comb begin
      min_addr = '1;
      for (int l = 0; l < LANES; l++) begin
         if (pend[l] && (blk_flat[l*ADDR_W +: ADDR_W] < min_addr))
            min_addr = blk_flat[l*ADDR_W +: ADDR_W];
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_hit
      assign hit[l] = pend[l] && (blk_flat[l*ADDR_W +: ADDR_W] == min_addr);
   end
endmodule

// File: rtl/wsp_splitter.sv
module wsp_splitter
   import wsp_pkg::*;
#(
   parameter int LANES        = 32,
   parameter int ADDR_W       = 32,
   parameter int LINE_BYTES   = 128,
   parameter int SECTOR_BYTES = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [LANES*ADDR_W-1:0] req_addr,
   input  logic [LANES-1:0]        req_mask,
   input  logic [1:0]              req_wsize,
   input  logic                    req_l2only,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [ADDR_W-1:0]       out_addr,
   output logic                    out_sector,
   output logic [LANES-1:0]        out_lanes,
   output logic                    done
);
   localparam logic [ADDR_W-1:0] LINE_OFS = ADDR_W'(LINE_BYTES - 1);
   localparam logic [ADDR_W-1:0] SECT_OFS = ADDR_W'(SECTOR_BYTES - 1);

   if (LANES < 4 || (LANES % 4) != 0) begin : g_bad_lanes
      $error("wsp_splitter: LANES must be a positive multiple of 4");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || (SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0
       || SECTOR_BYTES > LINE_BYTES) begin : g_bad_sizes
      $error("wsp_splitter: block sizes must be powers of two with sector <= line");
   end

   logic                    busy_q;
   logic [1:0]              grp_q, wsz_q;
   logic                    l2_q;
   logic [LANES-1:0]        mask_q, pend_q;
   logic [LANES*ADDR_W-1:0] addr_q;

   logic                    accept, fire, grp_empty, grp_last;
   logic [1:0]              grp_load, wsz_load;
   logic [LANES-1:0]        load_sel, hit;
   logic [LANES*ADDR_W-1:0] blk_flat;
   logic [ADDR_W-1:0]       min_addr;

   assign req_ready = !busy_q;
   assign accept    = req_valid && !busy_q;
   assign out_valid = busy_q && (pend_q != '0);
   assign fire      = out_valid && out_ready;
   assign grp_empty = busy_q && (pend_q == '0);
   assign grp_last  = (grp_q == wsp_last_group(wsz_q));
   assign done      = grp_empty && grp_last;

   assign grp_load  = accept ? 2'd0 : grp_q + 2'd1;
   assign wsz_load  = accept ? req_wsize : wsz_q;

   wsp_group_sel #(.LANES(LANES)) u_group_sel (
      .wsz (wsz_load),
      .grp (grp_load),
      .sel (load_sel)
   );

   wsp_blk_align #(
      .LANES(LANES), .ADDR_W(ADDR_W),
      .LINE_BYTES(LINE_BYTES), .SECTOR_BYTES(SECTOR_BYTES)
   ) u_blk_align (
      .addr_flat   (addr_q),
      .sector_mode (l2_q),
      .blk_flat    (blk_flat)
   );

   wsp_min_pick #(.LANES(LANES), .ADDR_W(ADDR_W)) u_min_pick (
      .blk_flat (blk_flat),
      .pend     (pend_q),
      .min_addr (min_addr),
      .hit      (hit)
   );

   assign out_addr   = min_addr;
   assign out_sector = l2_q;
   assign out_lanes  = hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         grp_q  <= '0;
         wsz_q  <= '0;
         l2_q   <= 1'b0;
         mask_q <= '0;
         pend_q <= '0;
         addr_q <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         grp_q  <= 2'd0;
         wsz_q  <= req_wsize;
         l2_q   <= req_l2only;
         mask_q <= req_mask;
         addr_q <= req_addr;
         pend_q <= req_mask & load_sel;
      end else if (busy_q) begin
         if (fire) begin
            pend_q <= pend_q & ~hit;
         end else if (grp_empty) begin
            if (grp_last) begin
               busy_q <= 1'b0;
            end else begin
               grp_q  <= grp_q + 2'd1;
               pend_q <= mask_q & load_sel;
            end
         end
      end
   end

   AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !req_ready); // R1
   AST_REQ_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done) |=> ($stable(addr_q) && $stable(mask_q) && $stable(l2_q))); // R1
   AST_ALIGN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_sector) |-> ((out_addr & LINE_OFS) == '0)); // R5
   AST_ALIGN_SECT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sector) |-> ((out_addr & SECT_OFS) == '0)); // R5
   AST_LANES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_lanes != '0) && ((out_lanes & ~mask_q) == '0))); // R6
   AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(fire) && (grp_q == $past(grp_q))) |-> (out_addr > $past(out_addr))); // R7
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_lanes)
                                     && $stable(out_sector))); // R8
   AST_DONE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !out_valid); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9
endmodule

// File: tb/wsp_splitter_bench.sv
module wsp_splitter_bench;
   localparam int LANES  = 32;
   localparam int ADDR_W = 32;
   localparam int NV     = 11;

   typedef struct packed {
      logic [31:0] base;
      logic [15:0] stride;
      logic        down;
      logic [31:0] mask;
      logic [1:0]  wsize;
      logic        l2;
      logic [1:0]  stall;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{32'h0000_1000, 16'd4,   1'b0, 32'hFFFF_FFFF, 2'd0, 1'b0, 2'd0},
      '{32'h0000_1040, 16'd4,   1'b0, 32'hFFFF_FFFF, 2'd0, 1'b0, 2'd1},
      '{32'h0000_2000, 16'd8,   1'b0, 32'hFFFF_FFFF, 2'd1, 1'b0, 2'd0},
      '{32'h0000_3000, 16'd16,  1'b0, 32'hFFFF_FFFF, 2'd2, 1'b1, 2'd2},
      '{32'h0000_4000, 16'd32,  1'b1, 32'hFFFF_FFFF, 2'd0, 1'b1, 2'd0},
      '{32'h0000_5004, 16'd0,   1'b0, 32'hA5A5_A5A5, 2'd1, 1'b0, 2'd1},
      '{32'h0000_6000, 16'd16,  1'b0, 32'h0000_FF00, 2'd2, 1'b0, 2'd0},
      '{32'h0000_7000, 16'd4,   1'b0, 32'h0000_0000, 2'd0, 1'b0, 2'd0},
      '{32'h0000_8010, 16'd16,  1'b1, 32'hF0F0_F0F0, 2'd3, 1'b1, 2'd2},
      '{32'h0000_9000, 16'd256, 1'b0, 32'hFFFF_FFFF, 2'd0, 1'b0, 2'd1},
      '{32'h0000_A07C, 16'd4,   1'b0, 32'hFFFF_FFFF, 2'd0, 1'b1, 2'd0}
   };

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    req_valid = 1'b0;
   logic                    req_ready;
   logic [LANES*ADDR_W-1:0] req_addr = '0;
   logic [LANES-1:0]        req_mask = '0;
   logic [1:0]              req_wsize = '0;
   logic                    req_l2only = 1'b0;
   logic                    out_valid;
   logic                    out_ready = 1'b1;
   logic [ADDR_W-1:0]       out_addr;
   logic                    out_sector;
   logic [LANES-1:0]        out_lanes;
   logic                    done;

   int checks = 0;
   int errors = 0;

   logic [31:0] exp_addr [64];
   logic [31:0] exp_mask [64];
   int          exp_n;

   always #5 clk = ~clk;

   wsp_splitter u_wsp_splitter (
      .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_mask, .req_wsize,
      .req_l2only, .out_valid, .out_ready, .out_addr, .out_sector, .out_lanes, .done
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   function automatic string tag_of(input int i);
      case (i)
         0, 1, 9: return "R2";
         2:       return "R3";
         3, 8:    return "R4";
         4:       return "R7";
         5:       return "R10";
         6, 7:    return "R6";
         default: return "R5";
      endcase
   endfunction

   function automatic logic [31:0] lane_addr(input vec_t v, input int l);
      int idx;
      idx = v.down ? (LANES - 1 - l) : l;
      return v.base + 32'(idx) * 32'(v.stride);
   endfunction

   task automatic build_exp(input vec_t v);
      int          ngrp, gsz, cnt;
      logic [31:0] gran, b, t;
      logic [31:0] blks [32];
      bit          found;
      exp_n = 0;
      ngrp  = (v.wsize == 2'd0) ? 1 : (v.wsize == 2'd1) ? 2 : 4;
      gsz   = LANES / ngrp;
      gran  = v.l2 ? 32'hFFFF_FFE0 : 32'hFFFF_FF80;
      for (int g = 0; g < ngrp; g++) begin
         cnt = 0;
         for (int l = g * gsz; l < (g + 1) * gsz; l++) begin
            if (v.mask[l]) begin
               b = lane_addr(v, l) & gran;
               found = 1'b0;
               for (int k = 0; k < cnt; k++) if (blks[k] == b) found = 1'b1;
               if (!found) begin blks[cnt] = b; cnt++; end
            end
         end
         for (int i = 1; i < cnt; i++) begin
            for (int j = i; j > 0; j--) begin
               if (blks[j] < blks[j-1]) begin
                  t = blks[j]; blks[j] = blks[j-1]; blks[j-1] = t;
               end
            end
         end
         for (int k = 0; k < cnt; k++) begin
            exp_addr[exp_n] = blks[k];
            exp_mask[exp_n] = '0;
            for (int l = g * gsz; l < (g + 1) * gsz; l++)
               if (v.mask[l] && ((lane_addr(v, l) & gran) == blks[k])) exp_mask[exp_n][l] = 1'b1;
            exp_n++;
         end
      end
   endtask

   task automatic run_vec(input int vi, input bit poke);
      vec_t        v;
      int          got, cyc;
      bit          seen_done, held, busy_err;
      logic [31:0] h_addr, h_lanes;
      logic        h_sec;
      string       tag;
      v   = VECS[vi];
      tag = tag_of(vi);
      build_exp(v);
      @(negedge clk);
      chk(req_ready, "R1 idle ready", 32'(req_ready), 32'd1);
      for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = lane_addr(v, l);
      req_mask = v.mask; req_wsize = v.wsize; req_l2only = v.l2; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (poke) begin
         for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = 32'hDEAD_0000 + 32'(l * 4096);
         req_mask = '1; req_wsize = 2'd0; req_l2only = ~v.l2; req_valid = 1'b1;
      end
      got = 0; cyc = 0; seen_done = 1'b0; held = 1'b0; busy_err = 1'b0;
      h_addr = '0; h_lanes = '0; h_sec = 1'b0;
      while (!seen_done && cyc < 2000) begin
         case (v.stall)
            2'd1:    out_ready = cyc[0];
            2'd2:    out_ready = ((cyc % 3) == 2);
            default: out_ready = 1'b1;
         endcase
         #1;
         if (req_ready) busy_err = 1'b1;
         if (held) begin
            chk(out_valid && out_addr == h_addr && out_lanes == h_lanes && out_sector == h_sec,
                "R8 record held under stall", out_addr, h_addr);
            held = 1'b0;
         end
         if (done) begin
            seen_done = 1'b1;
            chk(got == exp_n, "R9 done after last record", 32'(got), 32'(exp_n));
            chk(!out_valid, "R9 done without record", 32'(out_valid), 32'd0);
         end else if (out_valid) begin
            if (got >= exp_n) begin
               chk(1'b0, {tag, " extra record"}, out_addr, 32'hFFFF_FFFF);
            end else if (out_ready) begin
               chk(out_addr == exp_addr[got], {tag, " R7 record address"}, out_addr, exp_addr[got]);
               chk(out_lanes == exp_mask[got], {tag, " R7 record lanes"}, out_lanes, exp_mask[got]);
               chk(out_sector == v.l2, "R5 size flag", 32'(out_sector), 32'(v.l2));
            end else begin
               held = 1'b1; h_addr = out_addr; h_lanes = out_lanes; h_sec = out_sector;
            end
            if (out_ready) got++;
         end
         @(negedge clk);
         cyc++;
      end
      req_valid = 1'b0;
      out_ready = 1'b1;
      chk(seen_done, {tag, " R9 done seen"}, 32'(seen_done), 32'd1);
      chk(!busy_err, "R1 busy holds ready low", 32'(busy_err), 32'd0);
      #1;
      chk(req_ready && !out_valid, "R1 idle after done", 32'(req_ready), 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(!out_valid && !done, "R9 reset quiet", {30'd0, out_valid, done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(req_ready, "R1 ready after reset", 32'(req_ready), 32'd1);
      chk(!out_valid && !done, "R6 no record after reset", {30'd0, out_valid, done}, 32'd0);
      for (int i = 0; i < NV; i++) run_vec(i, 1'b0);
      run_vec(2, 1'b1);
      run_vec(6, 1'b1);
      run_vec(3, 1'b0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule